// File: doc/BRIEF.md
# Postfix Expression Stack Evaluator

This block is a zero-address execution unit. It evaluates arithmetic written in postfix order. Instruction tokens arrive one per cycle on a valid/ready handshake. Each token is one of four things:

- a push of a data-memory word onto an internal operand stack;
- a pop of the top entry into data memory;
- an addition;
- a multiplication.

The operators take both operands implicitly from the two topmost stack entries and leave a single result in their place. The current top of stack and the stack depth are visible on the ports at all times.

Data memory is internal and small. The instruction stream reaches it only through push and pop. A separate write port lets a test environment preload operands. Illegal stack use never corrupts the stack; instead it raises a sticky flag. There are two such cases: operating on too few entries, and pushing onto a full stack.

Top module: `rpn_stack_engine`

## Requirements
- R1: While the synchronous reset `rst` is high, `in_ready` is low. After reset, `in_ready` is high, depth is 0, `tos` is 0 and both flags are clear.
- R2: An accepted token with `in_op`=00 (push) loads data-memory word `in_addr` onto the stack. Depth grows by one, and the value appears on `tos` in the cycle after acceptance.
- R3: An accepted token with `in_op`=10 (add) replaces the two top entries with their sum modulo 2^16, so depth drops by one.
- R4: An accepted token with `in_op`=11 (multiply) replaces the two top entries with their product truncated to the low 16 bits, so depth drops by one.
- R5: An accepted token with `in_op`=01 (pop) writes the top entry to data-memory word `in_addr` and removes it from the stack.
- R6: A token presented with `in_valid` low changes neither the stack nor the flags.
- R7: An add or multiply issued with fewer than two entries, or a pop issued on an empty stack, sets `udf_flag` and leaves depth and `tos` unchanged.
- R8: A push issued while 8 entries are held sets `ovf_flag` and is discarded. Depth never exceeds 8.
- R9: When a pop and a preload write hit the same data-memory word in the same cycle, the popped value is the one stored.
- R10: A push that reads the same word a preload write targets in the same cycle loads the word's old value.
- R11: Both flags are sticky: once set, they stay set through later valid instructions until reset.
- R12: The token stream 3 4 * 5 6 * + shows tops of 3, 4, 12, 5, 6, 30, 42 and ends with depth 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction token valid |
| in_ready | output | 1 | Token accepted when high together with in_valid |
| in_op | input | 2 | Opcode: 00 push, 01 pop, 10 add, 11 multiply |
| in_addr | input | 4 | Data-memory word for push and pop |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 4 | Preload word address |
| pre_data | input | 16 | Preload data |
| tos | output | 16 | Top-of-stack value, 0 when empty |
| depth | output | 4 | Number of stack entries, 0 to 8 |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |

## Verification
Two pairs of functions can land in the same cycle:

- A pop and a preload write can target the same memory word at once. The bench drives both on one clock edge. It then pushes that word back, expecting the popped value.
- A push can read a word while the preload port writes it. The bench expects the pre-write value on `tos`, and the new value on a following push.

Overflow and underflow are also provoked next to valid arithmetic. This shows that the flags persist and that the stack is left intact.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_ADD  = 2'b10,
        OP_MUL  = 2'b11
    } rpn_op_e;

endpackage

// File: rtl/rpn_alu.sv
module rpn_alu #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              do_mul,
    output logic [WORD_W-1:0] res
);

    logic [WORD_W-1:0] sum_w;
    logic [WORD_W-1:0] prod_w;

    always_comb begin
        sum_w  = opa + opb;
        prod_w = opa * opb;
        res    = do_mul ? prod_w : sum_w;
    end

endmodule

// File: rtl/rpn_dmem.sv
module rpn_dmem #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 4,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              hi_we,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [WORD_W-1:0] hi_data,
    input  logic              lo_we,
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [WORD_W-1:0] lo_data
);

    logic [WORD_W-1:0] mem_q [WORDS];

    assign rd_data = mem_q[rd_addr];

    // the high-priority port is written last so it wins a collision
    always_ff @(posedge clk) begin
        if (lo_we) mem_q[lo_addr] <= lo_data;
        if (hi_we) mem_q[hi_addr] <= hi_data;
    end

endmodule

// File: rtl/rpn_stack_engine.sv
module rpn_stack_engine
    import rpn_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int STACK_DEPTH = 8,
    parameter int ADDR_W      = 4,
    localparam int CNT_W      = $clog2(STACK_DEPTH + 1),
    localparam int IDX_W      = $clog2(STACK_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [WORD_W-1:0] pre_data,
    output logic [WORD_W-1:0] tos,
    output logic [CNT_W-1:0]  depth,
    output logic              ovf_flag,
    output logic              udf_flag
);

    typedef struct packed {
        logic [STACK_DEPTH-1:0][WORD_W-1:0] stk;
        logic [CNT_W-1:0]                   cnt;
        logic                               ovf;
        logic                               udf;
    } eng_state_t;

    eng_state_t s_d, s_q;

    logic              accept;
    rpn_op_e           op;
    logic              full_q;
    logic              lt2_q;
    logic [IDX_W-1:0]  top_i, sec_i, push_i;
    logic [WORD_W-1:0] top_val, sec_val;
    logic [WORD_W-1:0] mem_rd, alu_res;
    logic              pop_we;

    assign in_ready = !rst;
    assign accept   = in_valid && in_ready;
    assign op       = rpn_op_e'(in_op);
    assign full_q   = (s_q.cnt == CNT_W'(STACK_DEPTH));
    assign lt2_q    = (s_q.cnt < CNT_W'(2));
    assign top_i    = IDX_W'(s_q.cnt - CNT_W'(1));
    assign sec_i    = IDX_W'(s_q.cnt - CNT_W'(2));
    assign push_i   = IDX_W'(s_q.cnt);
    assign top_val  = s_q.stk[top_i];
    assign sec_val  = s_q.stk[sec_i];

    rpn_dmem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dmem (
        .clk     (clk),
        .rd_addr (in_addr),
        .rd_data (mem_rd),
        .hi_we   (pop_we),
        .hi_addr (in_addr),
        .hi_data (top_val),
        .lo_we   (pre_we),
        .lo_addr (pre_addr),
        .lo_data (pre_data)
    );

    rpn_alu #(.WORD_W(WORD_W)) u_alu (
        .opa    (sec_val),
        .opb    (top_val),
        .do_mul (op == OP_MUL),
        .res    (alu_res)
    );

    always_comb begin
        s_d    = s_q;
        pop_we = 1'b0;
        if (accept) begin
            unique case (op)
                OP_PUSH: begin
                    if (full_q) begin
                        s_d.ovf = 1'b1;
                    end else begin
                        s_d.stk[push_i] = mem_rd;
                        s_d.cnt         = s_q.cnt + CNT_W'(1);
                    end
                end
                OP_POP: begin
                    if (s_q.cnt == '0) begin
                        s_d.udf = 1'b1;
                    end else begin
                        pop_we  = 1'b1;
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
                OP_ADD, OP_MUL: begin
                    if (lt2_q) begin
                        s_d.udf = 1'b1;
                    end else begin
                        s_d.stk[sec_i] = alu_res;
                        s_d.cnt        = s_q.cnt - CNT_W'(1);
                    end
                end
                default: s_d = s_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign tos      = (s_q.cnt == '0) ? '0 : top_val;
    assign depth    = s_q.cnt;
    assign ovf_flag = s_q.ovf;
    assign udf_flag = s_q.udf;

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        depth <= CNT_W'(STACK_DEPTH)); // R8

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_PUSH && !full_q) |=> depth == CNT_W'($past(depth) + CNT_W'(1))); // R2

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_PUSH && full_q) |=> ($stable(depth) && ovf_flag)); // R8

    AST_SHORT_OPERATOR: assert property (@(posedge clk) disable iff (rst)
        (accept && in_op[1] && lt2_q) |=> ($stable(depth) && $stable(tos) && udf_flag)); // R7

    AST_ARITH_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (accept && in_op[1] && !lt2_q) |=> depth == CNT_W'($past(depth) - CNT_W'(1))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!in_valid) |=> ($stable(depth) && $stable(tos))); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag); // R11

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        udf_flag |=> udf_flag); // R11

endmodule

// File: tb/sim_rpn_stack_engine.sv
module sim_rpn_stack_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = 2'b00;
    logic [3:0]  in_addr = 4'd0;
    logic        pre_we = 1'b0;
    logic [3:0]  pre_addr = 4'd0;
    logic [15:0] pre_data = 16'd0;
    logic [15:0] tos;
    logic [3:0]  depth;
    logic        ovf_flag, udf_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [1:0] PUSH = 2'b00, POP = 2'b01, ADD = 2'b10, MUL = 2'b11;

    always #4 clk = ~clk; // 125 MHz

    rpn_stack_engine u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr(in_addr), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .tos(tos), .depth(depth),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 ready low in reset", int'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic preload(input logic [3:0] a, input logic [15:0] d);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [3:0] a);
        in_valid = 1'b1; in_op = op; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 ready", int'(in_ready), 1);
        check("R1 depth", int'(depth), 0);
        check("R1 tos", int'(tos), 0);
        check("R1 flags", int'({ovf_flag, udf_flag}), 0);
    endtask

    task automatic t_rpn_chain();
        do_reset();
        preload(0, 3); preload(1, 4); preload(2, 5); preload(3, 6);
        issue(PUSH, 0); check("R12 R2 top 3", int'(tos), 3);
        issue(PUSH, 1); check("R12 top 4", int'(tos), 4);
        issue(MUL, 0);  check("R12 R4 top 12", int'(tos), 12);
        issue(PUSH, 2); check("R12 top 5", int'(tos), 5);
        issue(PUSH, 3); check("R12 top 6", int'(tos), 6);
        issue(MUL, 0);  check("R12 top 30", int'(tos), 30);
        issue(ADD, 0);  check("R12 R3 top 42", int'(tos), 42);
        check("R12 depth 1", int'(depth), 1);
    endtask

    task automatic t_expression_pop();
        do_reset();
        preload(4, 7); preload(5, 9); preload(6, 2); preload(7, 3);
        issue(PUSH, 4); issue(PUSH, 5); issue(ADD, 0);
        issue(PUSH, 6); issue(PUSH, 7); issue(ADD, 0);
        issue(MUL, 0);
        check("R4 product 80", int'(tos), 80);
        issue(POP, 8);
        check("R5 depth after pop", int'(depth), 0);
        issue(PUSH, 8);
        check("R5 stored value", int'(tos), 80);
    endtask

    task automatic t_wrap();
        do_reset();
        preload(9, 16'hFFFF); preload(10, 2);
        issue(PUSH, 9); issue(PUSH, 10); issue(ADD, 0);
        check("R3 sum wraps", int'(tos), 1);
        issue(PUSH, 9); issue(PUSH, 9); issue(MUL, 0);
        check("R4 product truncates", int'(tos), 1);
        check("R4 depth", int'(depth), 2);
    endtask

    task automatic t_idle();
        do_reset();
        preload(0, 11);
        issue(PUSH, 0);
        in_op = ADD; in_addr = 0; in_valid = 1'b0;
        @(negedge clk);
        check("R6 depth held", int'(depth), 1);
        check("R6 tos held", int'(tos), 11);
        check("R6 no flag", int'(udf_flag), 0);
    endtask

    task automatic t_underflow();
        do_reset();
        issue(ADD, 0);
        check("R7 udf on empty add", int'(udf_flag), 1);
        check("R7 depth 0", int'(depth), 0);
        preload(0, 21);
        issue(PUSH, 0);
        issue(MUL, 0);
        check("R7 depth kept", int'(depth), 1);
        check("R7 tos kept", int'(tos), 21);
        issue(POP, 1);
        issue(POP, 1);
        check("R7 pop empty depth", int'(depth), 0);
        issue(PUSH, 1);
        check("R11 udf sticky", int'(udf_flag), 1);
        check("R5 popped 21", int'(tos), 21);
        check("R7 no ovf", int'(ovf_flag), 0);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 8; i++) preload(4'(i), 16'(100 + i));
        preload(11, 999);
        for (int i = 0; i < 8; i++) issue(PUSH, 4'(i));
        check("R8 full depth", int'(depth), 8);
        check("R8 no ovf yet", int'(ovf_flag), 0);
        issue(PUSH, 11);
        check("R8 depth capped", int'(depth), 8);
        check("R8 push dropped", int'(tos), 107);
        check("R8 ovf set", int'(ovf_flag), 1);
        issue(POP, 12);
        check("R11 ovf sticky", int'(ovf_flag), 1);
        check("R5 tos after pop", int'(tos), 106);
    endtask

    task automatic t_collisions();
        do_reset();
        preload(13, 16'h0055);
        issue(PUSH, 13);
        in_valid = 1'b1; in_op = POP; in_addr = 14;
        pre_we = 1'b1; pre_addr = 14; pre_data = 16'hAAAA;
        @(negedge clk);
        in_valid = 1'b0; pre_we = 1'b0;
        issue(PUSH, 14);
        check("R9 pop wins", int'(tos), 16'h0055);
        preload(15, 16'h1234);
        in_valid = 1'b1; in_op = PUSH; in_addr = 15;
        pre_we = 1'b1; pre_addr = 15; pre_data = 16'h9999;
        @(negedge clk);
        in_valid = 1'b0; pre_we = 1'b0;
        check("R10 old word read", int'(tos), 16'h1234);
        issue(PUSH, 15);
        check("R10 new word after", int'(tos), 16'h9999);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rpn_chain();
        t_expression_pop();
        t_wrap();
        t_idle();
        t_underflow();
        t_overflow();
        t_collisions();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule